// File: doc/BRIEF.md
# Condition Field Register File

This block stores eight 4-bit condition fields and exposes the same storage through two views. The narrow view has three read ports and two write ports. Each one addresses fields through an 8-bit one-hot select vector rather than a binary index. The wide view has one read port and one write port that treat all eight fields as a single 32-bit word. The wide write carries one enable bit per field, so a single operation can update any subset of fields.

All writes arriving in a cycle are merged under a fixed priority. Narrow ports are ranked by port number, and the wide port ranks above every narrow port. The merged value is what gets stored at the clock edge. The same merged value also drives every read output combinationally during that cycle, so each read shows a same-cycle write. A synchronous active-high reset clears the storage.

Top module: `cfrf_top`

## Requirements
- R1: The wide read returns all eight fields as one 32-bit word. Field i occupies bits [31-4i : 28-4i], so field 0 is at 31:28 and field 7 is at 3:0.
- R2: Narrow read port k (k = 0..2) takes its select from `nrd_sel[8k+7:8k]`, and bit i of that slice selects field i. With exactly one bit set, the port returns that field on `nrd_data[4k+3:4k]`.
- R3: A narrow read with an all-zero select returns 0. A select with several bits set returns the bitwise OR of the selected fields.
- R4: Narrow write port j (j = 0..1) writes `nwr_data[4j+3:4j]` into every field i whose bit `nwr_sel[8j+i]` is set. An all-zero select leaves the storage unchanged.
- R5: The wide write updates field i from the matching 4-bit slice of `wwr_data` (R1 layout) only when `wwr_en[i]` is 1. Fields whose enable bit is 0 keep their value.
- R6: When several writes hit one field in the same cycle, the wide write wins over any narrow write. Among narrow writes, the higher-numbered port wins.
- R7: Every read output reflects, in the same cycle, the value the field will hold after the coming clock edge. This follows the R6 priority, so the wide read shows narrow writes and narrow reads show masked wide writes.
- R8: A field that no port writes keeps its value from one cycle to the next.
- R9: While `rst` is high, every read output is 0 and writes have no effect. After a clock edge with `rst` high, all fields hold 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nrd_sel | input | 24 | One-hot field selects, 8 bits per narrow read port |
| nrd_data | output | 12 | Narrow read data, 4 bits per port |
| nwr_sel | input | 16 | One-hot field selects, 8 bits per narrow write port |
| nwr_data | input | 8 | Narrow write data, 4 bits per port |
| wrd_data | output | 32 | Wide read word |
| wwr_en | input | 8 | Per-field enable for the wide write |
| wwr_data | input | 32 | Wide write word |

## Verification
Every read result is due in the same cycle as the stimulus that causes it, because the outputs are combinational views of the merged next value. The bench therefore drives inputs just after a falling edge and samples one nanosecond later, before the rising edge that commits them. Stored effects are checked one cycle later, in the next sampling window, where they must reappear with no write present. The reset check samples while reset is high and again in the first cycle after it is released.

// File: rtl/cfrf_pkg.sv
package cfrf_pkg;
    localparam int CF_FIELDS = 8;
    localparam int CF_WIDTH  = 4;
    localparam int CF_NRD    = 3;
    localparam int CF_NWR    = 2;

    // Field 0 sits at the most significant end of the wide word.
    function automatic int fld_lsb(input int nf, input int fw, input int idx);
        return (nf - 1 - idx) * fw;
    endfunction
endpackage

// File: rtl/cfrf_resolve.sv
module cfrf_resolve
    import cfrf_pkg::*;
#(
    parameter int NF  = CF_FIELDS,
    parameter int FW  = CF_WIDTH,
    parameter int NWR = CF_NWR
) (
    input  logic               rst,
    input  logic [NF*FW-1:0]   cur,
    input  logic [NWR*NF-1:0]  nwr_sel,
    input  logic [NWR*FW-1:0]  nwr_data,
    input  logic [NF-1:0]      wwr_en,
    input  logic [NF*FW-1:0]   wwr_data,
    output logic [NF*FW-1:0]   nxt
);
    for (genvar i = 0; i < NF; i++) begin : g_fld
        localparam int LSB = fld_lsb(NF, FW, i);
        logic [FW-1:0] val;

        // Later assignments override earlier ones: ascending narrow
        // port number, then the wide port, then reset.
        always_comb begin
            val = cur[LSB +: FW];
            for (int j = 0; j < NWR; j++) begin
                if (nwr_sel[j*NF + i]) begin
                    val = nwr_data[j*FW +: FW];
                end
            end
            if (wwr_en[i]) begin
                val = wwr_data[LSB +: FW];
            end
            if (rst) begin
                val = '0;
            end
        end

        assign nxt[LSB +: FW] = val;
    end
endmodule

// File: rtl/cfrf_rdmux.sv
module cfrf_rdmux
    import cfrf_pkg::*;
#(
    parameter int NF = CF_FIELDS,
    parameter int FW = CF_WIDTH
) (
    input  logic [NF-1:0]    sel,
    input  logic [NF*FW-1:0] fields,
    output logic [FW-1:0]    data
);
    always_comb begin
        data = '0;
        for (int i = 0; i < NF; i++) begin
            if (sel[i]) begin
                data = data | fields[fld_lsb(NF, FW, i) +: FW];
            end
        end
    end
endmodule

// File: rtl/cfrf_store.sv
module cfrf_store
    import cfrf_pkg::*;
#(
    parameter int NF = CF_FIELDS,
    parameter int FW = CF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NF*FW-1:0] d,
    output logic [NF*FW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/cfrf_top.sv
module cfrf_top
    import cfrf_pkg::*;
#(
    parameter int NF  = CF_FIELDS,
    parameter int FW  = CF_WIDTH,
    parameter int NRD = CF_NRD,
    parameter int NWR = CF_NWR
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NRD*NF-1:0]  nrd_sel,
    output logic [NRD*FW-1:0]  nrd_data,
    input  logic [NWR*NF-1:0]  nwr_sel,
    input  logic [NWR*FW-1:0]  nwr_data,
    output logic [NF*FW-1:0]   wrd_data,
    input  logic [NF-1:0]      wwr_en,
    input  logic [NF*FW-1:0]   wwr_data
);
    localparam int WW = NF * FW;

    logic [WW-1:0] stored;
    logic [WW-1:0] merged;

    cfrf_resolve #(.NF(NF), .FW(FW), .NWR(NWR)) u_resolve (
        .rst      (rst),
        .cur      (stored),
        .nwr_sel  (nwr_sel),
        .nwr_data (nwr_data),
        .wwr_en   (wwr_en),
        .wwr_data (wwr_data),
        .nxt      (merged)
    );

    cfrf_store #(.NF(NF), .FW(FW)) u_store (
        .clk (clk),
        .rst (rst),
        .d   (merged),
        .q   (stored)
    );

    // Write-through: every read view is taken from the merged next value.
    assign wrd_data = merged;

    for (genvar k = 0; k < NRD; k++) begin : g_rd
        cfrf_rdmux #(.NF(NF), .FW(FW)) u_mux (
            .sel    (nrd_sel[k*NF +: NF]),
            .fields (merged),
            .data   (nrd_data[k*FW +: FW])
        );
    end
endmodule

// File: rtl/cfrf_chk.sv
module cfrf_chk
    import cfrf_pkg::*;
#(
    parameter int NF  = CF_FIELDS,
    parameter int FW  = CF_WIDTH,
    parameter int NRD = CF_NRD,
    parameter int NWR = CF_NWR
) (
    input logic               clk,
    input logic               rst,
    input logic [NRD*NF-1:0]  nrd_sel,
    input logic [NRD*FW-1:0]  nrd_data,
    input logic [NWR*NF-1:0]  nwr_sel,
    input logic [NWR*FW-1:0]  nwr_data,
    input logic [NF*FW-1:0]   wrd_data,
    input logic [NF-1:0]      wwr_en,
    input logic [NF*FW-1:0]   wwr_data
);
    logic [NWR-1:0][NF-1:0] upper_hit;
    logic [NF-1:0]          any_wr;

    always_comb begin
        any_wr = wwr_en;
        for (int j = 0; j < NWR; j++) begin
            any_wr = any_wr | nwr_sel[j*NF +: NF];
            upper_hit[j] = '0;
            for (int h = j + 1; h < NWR; h++) begin
                upper_hit[j] = upper_hit[j] | nwr_sel[h*NF +: NF];
            end
        end
    end

    // R9: reset forces every read view to zero
    a_r9_reset_zero: assert property (@(posedge clk)
        rst |-> (wrd_data == '0 && nrd_data == '0));

    for (genvar k = 0; k < NRD; k++) begin : g_rp
        // R3: empty select reads zero
        a_r3_empty_sel: assert property (@(posedge clk) disable iff (rst)
            (nrd_sel[k*NF +: NF] == '0) |-> (nrd_data[k*FW +: FW] == '0));
        for (genvar i = 0; i < NF; i++) begin : g_f
            // R2: one-hot narrow read agrees with the wide view
            a_r2_narrow_view: assert property (@(posedge clk) disable iff (rst)
                (nrd_sel[k*NF + i] && $onehot0(nrd_sel[k*NF +: NF]))
                |-> (nrd_data[k*FW +: FW] == wrd_data[fld_lsb(NF, FW, i) +: FW]));
        end
    end

    for (genvar i = 0; i < NF; i++) begin : g_fc
        localparam int LSB = fld_lsb(NF, FW, i);
        // R6: wide write beats narrow; visible in the same cycle (R7)
        a_r6_wide_wins: assert property (@(posedge clk) disable iff (rst)
            wwr_en[i] |-> (wrd_data[LSB +: FW] == wwr_data[LSB +: FW]));
        // R8: unwritten field holds its value
        a_r8_hold: assert property (@(posedge clk) disable iff (rst)
            !any_wr[i] |-> (wrd_data[LSB +: FW] == $past(wrd_data[LSB +: FW])));
        for (genvar j = 0; j < NWR; j++) begin : g_w
            // R6: highest narrow port wins when the wide port is idle
            a_r6_narrow_prio: assert property (@(posedge clk) disable iff (rst)
                (nwr_sel[j*NF + i] && !wwr_en[i] && !upper_hit[j][i])
                |-> (wrd_data[LSB +: FW] == nwr_data[j*FW +: FW]));
        end
    end
endmodule

bind cfrf_top cfrf_chk #(.NF(NF), .FW(FW), .NRD(NRD), .NWR(NWR)) u_chk (.*);

// File: tb/tb_cfrf_top.sv
`timescale 1ns/1ps
module tb_cfrf_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [23:0] nrd_sel;
    logic [11:0] nrd_data;
    logic [15:0] nwr_sel;
    logic [7:0]  nwr_data;
    logic [31:0] wrd_data;
    logic [7:0]  wwr_en;
    logic [31:0] wwr_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cfrf_top dut (
        .clk(clk), .rst(rst),
        .nrd_sel(nrd_sel), .nrd_data(nrd_data),
        .nwr_sel(nwr_sel), .nwr_data(nwr_data),
        .wrd_data(wrd_data),
        .wwr_en(wwr_en), .wwr_data(wwr_data)
    );

    typedef struct packed {
        logic [7:0]  wen;
        logic [31:0] wdat;
        logic [7:0]  s1;
        logic [3:0]  d1;
        logic [7:0]  s0;
        logic [3:0]  d0;
        logic [7:0]  rs;
        logic [31:0] ew;
        logic [3:0]  er;
    } vec_t;

    // wen, wdat, sel1, dat1, sel0, dat0, read sel (port 0), exp wide, exp read
    localparam vec_t VT [8] = '{
        '{8'hFF, 32'h12345678, 8'h00, 4'h0, 8'h00, 4'h0, 8'h01, 32'h12345678, 4'h1}, // R1 R5 R7
        '{8'h00, 32'h00000000, 8'h00, 4'h0, 8'h00, 4'h0, 8'h80, 32'h12345678, 4'h8}, // R2 R8
        '{8'h0F, 32'hAAAABBBB, 8'h00, 4'h0, 8'h00, 4'h0, 8'h10, 32'hAAAA5678, 4'h5}, // R5
        '{8'h00, 32'h00000000, 8'h80, 4'h9, 8'h80, 4'h3, 8'h80, 32'hAAAA5679, 4'h9}, // R6 R7
        '{8'h02, 32'h0D000000, 8'h00, 4'h0, 8'h02, 4'hC, 8'h02, 32'hADAA5679, 4'hD}, // R6 R7
        '{8'h00, 32'h00000000, 8'h60, 4'h1, 8'h00, 4'hF, 8'h30, 32'hADAA5119, 4'h5}, // R4 R3
        '{8'h00, 32'h00000000, 8'h00, 4'h0, 8'h00, 4'h0, 8'h00, 32'hADAA5119, 4'h0}, // R3 R8
        '{8'h00, 32'hFFFFFFFF, 8'h00, 4'h0, 8'h00, 4'h0, 8'h03, 32'hADAA5119, 4'hF}  // R5 R3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_in();
        nrd_sel = '0; nwr_sel = '0; nwr_data = '0; wwr_en = '0; wwr_data = '0;
    endtask

    // Drive after the falling edge, sample 1 ns later, before the rising edge.
    task automatic to_slot();
        @(negedge clk);
        idle_in();
    endtask

    initial begin
        rst = 1'b1;
        idle_in();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R9: storage clear after reset, all read ports select everything
        to_slot();
        nrd_sel = {3{8'hFF}};
        #1;
        chk("R9 wide after reset", wrd_data, 32'h0);
        chk("R9 port0 after reset", {28'h0, nrd_data[3:0]}, 32'h0);
        chk("R9 port1 after reset", {28'h0, nrd_data[7:4]}, 32'h0);
        chk("R9 port2 after reset", {28'h0, nrd_data[11:8]}, 32'h0);

        for (int v = 0; v < 8; v++) begin
            to_slot();
            wwr_en   = VT[v].wen;
            wwr_data = VT[v].wdat;
            nwr_sel  = {VT[v].s1, VT[v].s0};
            nwr_data = {VT[v].d1, VT[v].d0};
            nrd_sel  = {16'h0, VT[v].rs};
            #1;
            chk($sformatf("R7 vector %0d wide", v), wrd_data, VT[v].ew);
            chk($sformatf("R2 vector %0d port0", v), {28'h0, nrd_data[3:0]}, {28'h0, VT[v].er});
        end

        // R2: ports 1 and 2 with state ADAA5119
        to_slot();
        nrd_sel = {8'h80, 8'h04, 8'h20};
        #1;
        chk("R2 port0 field5", {28'h0, nrd_data[3:0]}, 32'h1);
        chk("R2 port1 field2", {28'h0, nrd_data[7:4]}, 32'hA);
        chk("R2 port2 field7", {28'h0, nrd_data[11:8]}, 32'h9);

        // R6: both narrow ports and the wide port hit field 3
        to_slot();
        nwr_sel  = {8'h08, 8'h08};
        nwr_data = {4'h3, 4'h2};
        wwr_en   = 8'h08;
        wwr_data = 32'h000E0000;
        nrd_sel  = {8'h08, 16'h0};
        #1;
        chk("R6 three-way read", {28'h0, nrd_data[11:8]}, 32'hE);
        to_slot();
        #1;
        chk("R8 after three-way", wrd_data, 32'hADAE5119);

        // R4: multi-bit narrow write on fields 0 and 7
        to_slot();
        nwr_sel  = {8'h00, 8'h81};
        nwr_data = {4'h0, 4'h6};
        #1;
        chk("R4 multi-field write", wrd_data, 32'h6DAE5116);

        // R9: reset with writes present
        @(negedge clk);
        rst = 1'b1;
        wwr_en = 8'hFF; wwr_data = 32'hFFFFFFFF;
        nwr_sel = {8'hFF, 8'hFF}; nwr_data = 8'hFF;
        nrd_sel = {3{8'hFF}};
        #1;
        chk("R9 wide during reset", wrd_data, 32'h0);
        chk("R9 narrow during reset", {20'h0, nrd_data}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        idle_in();
        #1;
        chk("R9 wide after reset pulse", wrd_data, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule